// File: doc/BRIEF.md
# Voltage Identification Reference Ramp Sequencer

This block turns a 5-bit voltage-identification code into a target reference in millivolts. It then walks a digital reference register toward that target in bounded steps, one step per rate strobe. After enable it climbs slowly from zero until it reaches a fixed handover level of 900 mV. That point marks soft start as complete. From then on the reference moves twenty times faster, and it follows any later code change up or down at that fast rate.

Power-good logic downstream uses the done flag to qualify its output. Two code values mean that no processor is fitted. Either one raises a shutdown request and freezes the ramp. While soft start is done, every registered change of the code also produces a one-cycle pulse. The analog conversion of the reference is outside this block.

Top module: `vid_ramp_seq`

## Requirements
- R1: With code bit 4 equal to 0 and the low four bits n in 0..14, targetMv is 2000 - 50*n (for example 00000 gives 2000 and 01110 gives 1300).
- R2: With code bit 4 equal to 1 and the low four bits n in 0..14, targetMv is 1275 - 25*n (for example 10000 gives 1275 and 11110 gives 925).
- R3: Codes 01111 and 11111 drive shutdownReq high and targetMv to 0, and refMv holds its value while either code is registered, even when tick is high.
- R4: vidCode is captured into a register on every clock edge, so targetMv and shutdownReq follow it one cycle later. refMv moves only on edges where tick is high.
- R5: While ssDone is low and enable is high, each tick adds 1 mV to refMv. The tick that brings refMv to 900 sets ssDone.
- R6: While ssDone is high, each tick moves refMv 20 mV toward targetMv, upward or downward. The last step lands exactly on targetMv, and refMv stays there on further ticks.
- R7: With enable low, refMv becomes 0 and ssDone clears on the next edge. Code decoding still works while enable is low.
- R8: codeChange is high for the single cycle after an edge at which the captured code changed while enable and ssDone were both high. It stays low for a code change during soft start.
- R9: In reset, refMv is 0, ssDone is 0, codeChange is 0 and the captured code is 00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low clears the ramp |
| vidCode | input | 5 | Voltage-identification code |
| tick | input | 1 | Rate strobe; one ramp step per high cycle |
| refMv | output | 12 | Active reference in millivolts |
| targetMv | output | 12 | Decoded target in millivolts (0 for no-processor codes) |
| ssDone | output | 1 | Soft start complete |
| shutdownReq | output | 1 | No-processor code registered |
| codeChange | output | 1 | One-cycle pulse on a code change after soft start |

## Verification
The bench targets the exact tick counts at both ends of the soft-start climb: 899 after 899 ticks with done still low, then 900 with done set. A design that is off by one or sets done early breaks this check. It checks the partial final fast step in both directions, 940 to 925 and 1265 to 1275. A design that does not clamp overshoots here. A design that snaps to the target lands a step early. It holds a no-processor code under active ticks, which catches a ramp that chases the zero target. It also changes the code during soft start, where a pulse that ignores the done flag would fire.

// File: rtl/vid_ramp_pkg.sv
package vid_ramp_pkg;

  localparam int unsigned HI_BASE_MV = 2000;
  localparam int unsigned HI_STEP_MV = 50;
  localparam int unsigned LO_BASE_MV = 1275;
  localparam int unsigned LO_STEP_MV = 25;
  localparam int unsigned CODE_W     = 5;

  typedef struct packed {
    logic clear;
    logic slowUp;
    logic fastMove;
  } rampCmd_t;

  function automatic logic isNoCpu(input logic [CODE_W-1:0] code);
    return code[CODE_W-2:0] == '1;
  endfunction

  function automatic int unsigned decodeVid(input logic [CODE_W-1:0] code);
    int unsigned idx;
    idx = int'(code[CODE_W-2:0]);
    if (isNoCpu(code)) return 0;
    if (code[CODE_W-1]) return LO_BASE_MV - LO_STEP_MV * idx;
    return HI_BASE_MV - HI_STEP_MV * idx;
  endfunction

endpackage

// File: rtl/vid_ramp_ctrl.sv
module vid_ramp_ctrl
  import vid_ramp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CODE_W-1:0] vidCode,
  input  logic              tick,
  input  logic              reachHandover,
  output logic [CODE_W-1:0] vidReg,
  output logic              ssDone,
  output logic              codeChange,
  output logic              shutdownReq,
  output rampCmd_t          cmd
);

  logic noCpu;

  always_comb begin
    noCpu        = isNoCpu(vidReg);
    shutdownReq  = noCpu;
    cmd.clear    = !enable;
    cmd.slowUp   = enable && tick && !noCpu && !ssDone;
    cmd.fastMove = enable && tick && !noCpu && ssDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vidReg     <= '0;
      ssDone     <= 1'b0;
      codeChange <= 1'b0;
    end else begin
      vidReg     <= vidCode;
      codeChange <= enable && ssDone && (vidCode != vidReg);
      if (!enable)
        ssDone <= 1'b0;
      else if (cmd.slowUp && reachHandover)
        ssDone <= 1'b1;
    end
  end

  // R5: once set, done only clears through enable
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ssDone && enable) |=> ssDone);

  // R8: the pulse is only raised after soft start
  assert_pulse_after_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    codeChange |-> ssDone);

endmodule

// File: rtl/vid_ramp_datapath.sv
module vid_ramp_datapath
  import vid_ramp_pkg::*;
#(
  parameter int unsigned MV_W        = 12,
  parameter int unsigned SLOW_STEP   = 1,
  parameter int unsigned FAST_STEP   = 20,
  parameter int unsigned HANDOVER_MV = 900
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampCmd_t          cmd,
  input  logic [CODE_W-1:0] vidReg,
  output logic [MV_W-1:0]   refMv,
  output logic [MV_W-1:0]   targetMv,
  output logic              reachHandover
);

  localparam int unsigned SUM_W = MV_W + 1;
  localparam logic [SUM_W-1:0] SLOW_S = SUM_W'(SLOW_STEP);
  localparam logic [SUM_W-1:0] FAST_S = SUM_W'(FAST_STEP);
  localparam logic [SUM_W-1:0] HAND_S = SUM_W'(HANDOVER_MV);

  logic [SUM_W-1:0] refWide, tgtWide, slowSum, upGap, downGap;
  logic [MV_W-1:0]  refNext;

  always_comb begin
    targetMv      = MV_W'(decodeVid(vidReg));
    refWide       = {1'b0, refMv};
    tgtWide       = {1'b0, targetMv};
    slowSum       = refWide + SLOW_S;
    reachHandover = slowSum >= HAND_S;
    upGap         = tgtWide - refWide;
    downGap       = refWide - tgtWide;
    refNext       = refMv;
    if (cmd.clear) begin
      refNext = '0;
    end else if (cmd.slowUp) begin
      refNext = reachHandover ? MV_W'(HANDOVER_MV) : slowSum[MV_W-1:0];
    end else if (cmd.fastMove) begin
      if (refMv < targetMv)
        refNext = (upGap <= FAST_S) ? targetMv : MV_W'(refWide + FAST_S);
      else if (refMv > targetMv)
        refNext = (downGap <= FAST_S) ? targetMv : MV_W'(refWide - FAST_S);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) refMv <= '0;
    else       refMv <= refNext;
  end

  // R4: without a command the reference stays put
  assert_hold_without_cmd_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.clear && !cmd.slowUp && !cmd.fastMove) |=> $stable(refMv));

  // R6: an upward fast step never passes the target
  assert_no_overshoot_up_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.fastMove && refMv <= targetMv) |=> refMv <= $past(targetMv));

  // R6: a downward fast step never passes the target
  assert_no_overshoot_down_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.fastMove && refMv >= targetMv) |=> refMv >= $past(targetMv));

  // R5: the slow climb never passes the handover level
  assert_slow_bounded_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.slowUp |=> refMv <= MV_W'(HANDOVER_MV));

endmodule

// File: rtl/vid_ramp_seq.sv
module vid_ramp_seq
  import vid_ramp_pkg::*;
#(
  parameter int unsigned MV_W        = 12,
  parameter int unsigned SLOW_STEP   = 1,
  parameter int unsigned FAST_STEP   = 20,
  parameter int unsigned HANDOVER_MV = 900
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [4:0]        vidCode,
  input  logic              tick,
  output logic [MV_W-1:0]   refMv,
  output logic [MV_W-1:0]   targetMv,
  output logic              ssDone,
  output logic              shutdownReq,
  output logic              codeChange
);

  rampCmd_t          cmd;
  logic [CODE_W-1:0] vidReg;
  logic              reachHandover;

  vid_ramp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .vidCode(vidCode), .tick(tick),
    .reachHandover(reachHandover), .vidReg(vidReg), .ssDone(ssDone),
    .codeChange(codeChange), .shutdownReq(shutdownReq), .cmd(cmd)
  );

  vid_ramp_datapath #(
    .MV_W(MV_W), .SLOW_STEP(SLOW_STEP), .FAST_STEP(FAST_STEP), .HANDOVER_MV(HANDOVER_MV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .vidReg(vidReg),
    .refMv(refMv), .targetMv(targetMv), .reachHandover(reachHandover)
  );

  // R7: disabling clears the ramp and the done flag
  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (refMv == '0 && !ssDone));

  // R3: a no-processor code freezes the reference
  assert_shutdown_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (shutdownReq && enable) |=> $stable(refMv));

  // R3: a no-processor code yields a zero target
  assert_shutdown_target_R3: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> targetMv == '0);

endmodule

// File: tb/vid_ramp_seq_tb.sv
module vid_ramp_seq_tb;

  logic        clk = 1'b0;
  logic        rstN, enable, tick;
  logic [4:0]  vidCode;
  logic [11:0] refMv, targetMv;
  logic        ssDone, shutdownReq, codeChange;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vid_ramp_seq u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .vidCode(vidCode), .tick(tick),
    .refMv(refMv), .targetMv(targetMv), .ssDone(ssDone),
    .shutdownReq(shutdownReq), .codeChange(codeChange)
  );

  // {code, expected target, expected shutdown}
  localparam logic [17:0] VEC [12] = '{
    {5'b00000, 12'd2000, 1'b0}, {5'b00001, 12'd1950, 1'b0},
    {5'b00111, 12'd1650, 1'b0}, {5'b01110, 12'd1300, 1'b0},
    {5'b01111, 12'd0,    1'b1}, {5'b10000, 12'd1275, 1'b0},
    {5'b10001, 12'd1250, 1'b0}, {5'b10110, 12'd1125, 1'b0},
    {5'b11000, 12'd1075, 1'b0}, {5'b11101, 12'd950,  1'b0},
    {5'b11110, 12'd925,  1'b0}, {5'b11111, 12'd0,    1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runTicks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; enable = 1'b0; tick = 1'b0; vidCode = 5'b00000;
    repeat (3) @(negedge clk);
    chk("R9 ref in reset", int'(refMv), 0);
    chk("R9 done in reset", int'(ssDone), 0);
    chk("R9 pulse in reset", int'(codeChange), 0);
    chk("R9 target of reset code", int'(targetMv), 2000);
    rstN = 1'b1;

    for (int i = 0; i < 12; i++) begin
      vidCode = VEC[i][17:13];
      @(negedge clk);
      chk(VEC[i][17] ? "R2 decode target" : "R1 decode target", int'(targetMv), int'(VEC[i][12:1]));
      chk("R3 shutdown flag", int'(shutdownReq), int'(VEC[i][0]));
      chk("R7 ref while disabled", int'(refMv), 0);
    end

    vidCode = 5'b00000;
    @(negedge clk);
    enable = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 no move without tick", int'(refMv), 0);
    runTicks(1);
    chk("R5 first slow step", int'(refMv), 1);
    runTicks(898);
    chk("R5 ref before handover", int'(refMv), 899);
    chk("R5 done low before handover", int'(ssDone), 0);
    runTicks(1);
    chk("R5 ref at handover", int'(refMv), 900);
    chk("R5 done at handover", int'(ssDone), 1);
    runTicks(54);
    chk("R6 fast climb", int'(refMv), 1980);
    runTicks(1);
    chk("R6 clamp up to target", int'(refMv), 2000);
    runTicks(1);
    chk("R6 stays at target", int'(refMv), 2000);

    vidCode = 5'b11110;
    @(negedge clk);
    chk("R8 pulse on change", int'(codeChange), 1);
    chk("R4 target follows code", int'(targetMv), 925);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(codeChange), 0);
    runTicks(53);
    chk("R6 fast descent", int'(refMv), 940);
    runTicks(1);
    chk("R6 clamp down to target", int'(refMv), 925);

    vidCode = 5'b10000;
    @(negedge clk);
    @(negedge clk);
    runTicks(17);
    chk("R6 fast climb second", int'(refMv), 1265);
    runTicks(1);
    chk("R6 partial last step", int'(refMv), 1275);

    vidCode = 5'b01111;
    @(negedge clk);
    chk("R3 shutdown asserted", int'(shutdownReq), 1);
    runTicks(10);
    chk("R3 ref held", int'(refMv), 1275);
    vidCode = 5'b10001;
    @(negedge clk);
    chk("R3 shutdown released", int'(shutdownReq), 0);
    runTicks(1);
    chk("R6 resume descent", int'(refMv), 1255);
    runTicks(1);
    chk("R6 resume clamp", int'(refMv), 1250);

    enable = 1'b0;
    @(negedge clk);
    chk("R7 ref cleared", int'(refMv), 0);
    chk("R7 done cleared", int'(ssDone), 0);
    enable = 1'b1;
    runTicks(10);
    chk("R5 restart slow", int'(refMv), 10);
    vidCode = 5'b00001;
    @(negedge clk);
    chk("R8 no pulse in soft start", int'(codeChange), 0);
    chk("R4 hold without tick", int'(refMv), 10);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule